// File: doc/BRIEF.md
# Bidirectional 8-bit Timer/Counter with Buffered Compare

The block is an up/down counter that advances only on a single-cycle enable strobe. A two-bit source field in the control register selects that strobe: none, an internal prescaled tick, or a tick from an asynchronous oscillator that has already been brought into the system clock domain. Every flop runs on the system clock alone.

The wrap point (TOP) depends on the mode. In the free-running mode it is the all-ones value (MAX). In the compare-top mode it is the active compare value. The compare value is double-buffered. Software writes a buffer, and the buffer is copied to the active register only while the count is zero (BOTTOM), so a change never produces a truncated period. Each count strobe compares the count with the active compare value. A match sets a sticky compare flag. A wrap at the end of the sequence sets a sticky overflow flag. Both flags can serve as interrupt requests.

Software uses a write-only register port with four addresses: control, counter load, compare buffer and flag clear. The count, the active compare value and both flags are driven directly as outputs.

Top module: `bidir_timer`

## Requirements
- R1: After reset the count, the active compare value, both flags and the control register are all zero, so the source is none, the mode is free-running and the direction is up.
- R2: The source field is control bits [1:0]. Value 1 selects int_tick_i, value 2 selects async_tick_i, and values 0 and 3 select no source. With no source selected the count holds. A strobe on the input that is not selected has no effect.
- R3: Control bit 2 = 0 selects the free-running mode and control bit 3 = 0 selects up counting. In that setting each selected strobe adds one to the count. From 0xFF the count goes to 0x00 and the overflow flag is set.
- R4: When control bit 3 = 1 the count goes down by one on each strobe. At 0x00 a strobe loads TOP and sets the overflow flag. TOP is 0xFF in the free-running mode and the active compare value in the compare-top mode.
- R5: Control bit 2 = 1 selects the compare-top mode. In that mode, with up counting, a strobe that sees the count equal to the active compare value returns the count to 0x00 and sets the overflow flag.
- R6: In either mode, a strobe that sees the count equal to the active compare value sets the compare flag, unless R9 blocks it.
- R7: A write to address 2 updates only the compare buffer. The buffer is copied into the active compare value (cmp_o) on each clock where the count is 0x00.
- R8: The flags stay set until a write to address 3. In that write, data bit 0 = 1 clears the compare flag and data bit 1 = 1 clears the overflow flag. When a flag-setting event and its clear fall in the same cycle, the flag ends up set.
- R9: A write to address 1 loads the count and takes precedence over a strobe in the same cycle. That strobe then neither advances the count nor sets a flag. The load also suppresses the compare match on the next strobe. Writes to address 0 load control bits [3:0] from wr_data_i[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| int_tick_i | input | 1 | Internal prescaled count strobe |
| async_tick_i | input | 1 | Oscillator count strobe, already synchronized |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register address: 0 control, 1 counter, 2 compare buffer, 3 flag clear |
| wr_data_i | input | 8 | Register write data |
| cnt_o | output | 8 | Current count |
| cmp_o | output | 8 | Active compare value |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
Two collisions can fall in the same cycle. The first is a flag-setting strobe (a match and a wrap in the compare-top mode) together with a software flag clear. The second is a counter load together with a count strobe. The bench provokes both on purpose. It walks the count up to the compare value and issues the clear in the very cycle of the terminal strobe, and it issues a load in a strobe cycle. It then judges the result against a behavioural reference model: a flag that survives, a count that holds the loaded value, and a match that is suppressed on the following strobe. A long random phase mixes loads, clears, compare writes and mode changes with strobes, so that these collisions also occur unplanned.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_CLR  = 2'd3
  } bt_addr_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_INT   = 2'd1,
    SRC_ASYNC = 2'd2,
    SRC_OFF   = 2'd3
  } bt_src_e;

  typedef struct packed {
    logic    dir_down;
    logic    top_cmp;
    bt_src_e src;
  } bt_ctrl_t;
endpackage

// File: rtl/bt_ctrl_regs.sv
module bt_ctrl_regs
  import bt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             at_bottom_i,
  output bt_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0] cmp_act_o
);
  localparam int CTRL_W = $bits(bt_ctrl_t);

  bt_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] buf_q, act_q;
  logic             wr_ctrl, wr_cmp;

  assign wr_ctrl = wr_en_i && (bt_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign wr_cmp  = wr_en_i && (bt_addr_e'(wr_addr_i) == ADDR_CMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      act_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bt_ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_cmp) buf_q <= wr_data_i;
      // transfer only at BOTTOM: period never truncated
      if (at_bottom_i) act_q <= buf_q;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign cmp_act_o = act_q;

  // R7
  buf_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(at_bottom_i));
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dir_down_i,
  input  logic             top_cmp_i,
  input  logic [CNT_W-1:0] cmp_act_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_bottom_o,
  output logic             wrap_o,
  output logic             match_o
);
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t MAX_V = '1;

  cnt_t cnt_q, cnt_d, top_v;
  logic blk_q, adv, at_top, at_bot;

  assign top_v  = top_cmp_i ? cmp_act_i : MAX_V;
  assign adv    = tick_i & ~load_i;
  assign at_bot = (cnt_q == '0);
  assign at_top = (cnt_q == top_v);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i) begin
      if (dir_down_i) cnt_d = at_bot ? top_v : cnt_q - 1'b1;
      else            cnt_d = at_top ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      // load masks the match of the next strobe
      if (load_i)      blk_q <= 1'b1;
      else if (tick_i) blk_q <= 1'b0;
    end
  end

  assign cnt_o       = cnt_q;
  assign at_bottom_o = at_bot;
  assign wrap_o      = adv & (dir_down_i ? at_bot : at_top);
  assign match_o     = adv & ~blk_q & (cnt_q == cmp_act_i);

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_i |=> $stable(cnt_q));
  // R3
  up_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && !dir_down_i && !top_cmp_i |=> cnt_q == cnt_t'($past(cnt_q) + 1'b1));
  // R4
  down_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && dir_down_i && !top_cmp_i |=> cnt_q == cnt_t'($past(cnt_q) - 1'b1));
  // R5
  top_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv && top_cmp_i && !dir_down_i && (cnt_q == cmp_act_i) |=> cnt_q == '0);
  // R9
  load_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/bt_flags.sv
module bt_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_cmp_i,
  input  logic       set_ovf_i,
  input  logic [1:0] clr_i,
  output logic       cmp_flag_o,
  output logic       ovf_flag_o
);
  logic cmp_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      // set wins over a same-cycle clear
      cmp_q <= set_cmp_i | (cmp_q & ~clr_i[0]);
      ovf_q <= set_ovf_i | (ovf_q & ~clr_i[1]);
    end
  end

  assign cmp_flag_o = cmp_q;
  assign ovf_flag_o = ovf_q;

  // R8
  cmp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q && !clr_i[0] |=> cmp_q);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !clr_i[1] |=> ovf_q);
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_cmp_i |=> cmp_q);
  // R6
  cmp_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_q) |-> $past(set_cmp_i));
endmodule

// File: rtl/bidir_timer.sv
module bidir_timer
  import bt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_tick_i,
  input  logic             async_tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             cmp_flag_o,
  output logic             ovf_flag_o
);
  bt_ctrl_t         ctrl;
  logic [CNT_W-1:0] cmp_act;
  logic             tick, load, at_bottom, wrap, match;
  logic [1:0]       clr;

  always_comb begin
    unique case (ctrl.src)
      SRC_INT:   tick = int_tick_i;
      SRC_ASYNC: tick = async_tick_i;
      default:   tick = 1'b0;
    endcase
  end

  assign load = wr_en_i && (bt_addr_e'(wr_addr_i) == ADDR_CNT);
  assign clr  = (wr_en_i && (bt_addr_e'(wr_addr_i) == ADDR_CLR)) ? wr_data_i[1:0] : 2'b00;

  bt_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .at_bottom_i (at_bottom),
    .ctrl_o      (ctrl),
    .cmp_act_o   (cmp_act)
  );

  bt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .load_i      (load),
    .load_val_i  (wr_data_i),
    .dir_down_i  (ctrl.dir_down),
    .top_cmp_i   (ctrl.top_cmp),
    .cmp_act_i   (cmp_act),
    .cnt_o       (cnt_o),
    .at_bottom_o (at_bottom),
    .wrap_o      (wrap),
    .match_o     (match)
  );

  bt_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_cmp_i  (match),
    .set_ovf_i  (wrap),
    .clr_i      (clr),
    .cmp_flag_o (cmp_flag_o),
    .ovf_flag_o (ovf_flag_o)
  );

  assign cmp_o = cmp_act;
endmodule

// File: tb/bidir_timer_tb_top.sv
`timescale 1ns/1ps
module bidir_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       it_r = 1'b0, at_r = 1'b0, we_r = 1'b0;
  logic [1:0] wa_r = 2'd0;
  logic [7:0] wd_r = 8'd0;
  logic [7:0] cnt_o, cmp_o;
  logic       cmp_flag_o, ovf_flag_o;

  int errs = 0, checks = 0, cyc_n = 0;

  // reference model state
  int m_cnt, m_act, m_buf, m_src, m_mode, m_dir, m_cf, m_of, m_blk;

  always #2 clk_i = ~clk_i;

  bidir_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .int_tick_i(it_r), .async_tick_i(at_r),
    .wr_en_i(we_r), .wr_addr_i(wa_r), .wr_data_i(wd_r),
    .cnt_o(cnt_o), .cmp_o(cmp_o),
    .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin : model
    int tk, ld, top, nc, mt, wp;
    if (!rst_ni) begin
      m_cnt = 0; m_act = 0; m_buf = 0; m_src = 0; m_mode = 0;
      m_dir = 0; m_cf = 0; m_of = 0; m_blk = 0;
    end else begin
      tk  = (m_src == 1) ? int'(it_r) : (m_src == 2) ? int'(at_r) : 0;
      ld  = (we_r && wa_r == 2'd1) ? 1 : 0;
      top = m_mode ? m_act : 255;
      nc  = m_cnt; mt = 0; wp = 0;
      if (ld) nc = int'(wd_r);
      else if (tk) begin
        mt = (m_cnt == m_act && !m_blk) ? 1 : 0;
        if (m_dir) begin
          if (m_cnt == 0) begin nc = top; wp = 1; end else nc = m_cnt - 1;
        end else begin
          if (m_cnt == top) begin nc = 0; wp = 1; end else nc = (m_cnt + 1) % 256;
        end
      end
      if (m_cnt == 0) m_act = m_buf;
      if (ld) m_blk = 1; else if (tk) m_blk = 0;
      if (we_r && wa_r == 2'd3) begin
        if (wd_r[0]) m_cf = 0;
        if (wd_r[1]) m_of = 0;
      end
      if (mt) m_cf = 1;
      if (wp) m_of = 1;
      if (we_r && wa_r == 2'd0) begin
        m_src = int'(wd_r[1:0]); m_mode = int'(wd_r[2]); m_dir = int'(wd_r[3]);
      end
      if (we_r && wa_r == 2'd2) m_buf = int'(wd_r);
      m_cnt = nc;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("model cnt R2 R3 R4 R5 R9", int'(cnt_o), m_cnt);
      chk("model cmp R7", int'(cmp_o), m_act);
      chk("model cmp_flag R6 R8", int'(cmp_flag_o), m_cf);
      chk("model ovf_flag R3 R8", int'(ovf_flag_o), m_of);
    end
  end

  always @(posedge clk_i) begin
    cyc_n++;
    if (cyc_n > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog act=%0d exp=done", cyc_n);
      report();
      $finish;
    end
  end

  task automatic cyc(bit we, int a, int d, bit it, bit at);
    we_r = we; wa_r = 2'(a); wd_r = 8'(d); it_r = it; at_r = at;
    @(negedge clk_i);
    we_r = 1'b0; it_r = 1'b0; at_r = 1'b0;
  endtask

  task automatic wr(int a, int d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic ticks(int n, bit it, bit at);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, it, at);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    chk("R1 cnt", int'(cnt_o), 0);
    chk("R1 cmp", int'(cmp_o), 0);
    chk("R1 flags", int'({cmp_flag_o, ovf_flag_o}), 0);
    ticks(4, 1'b1, 1'b1);
    chk("R1 R2 no source after reset", int'(cnt_o), 0);
    // R2: source 3 and async-only selection
    wr(0, 3); ticks(4, 1'b1, 1'b1);
    chk("R2 src 3 holds", int'(cnt_o), 0);
    wr(0, 2); ticks(5, 1'b1, 1'b0);
    chk("R2 unselected strobe ignored", int'(cnt_o), 0);
    ticks(3, 1'b0, 1'b1);
    chk("R2 async strobe counts", int'(cnt_o), 3);
    // R3
    wr(0, 1); wr(1, 8'hFD); ticks(3, 1'b1, 1'b0);
    chk("R3 wrap to 0", int'(cnt_o), 0);
    chk("R3 ovf set", int'(ovf_flag_o), 1);
    wr(3, 2);
    chk("R8 ovf cleared", int'(ovf_flag_o), 0);
    // R7 / R6
    wr(2, 5); ticks(1, 1'b0, 1'b0);
    chk("R7 buffer moved at bottom", int'(cmp_o), 5);
    ticks(6, 1'b1, 1'b0);
    chk("R6 count past compare", int'(cnt_o), 6);
    chk("R6 cmp flag", int'(cmp_flag_o), 1);
    wr(2, 3); ticks(1, 1'b0, 1'b0);
    chk("R7 buffer held off bottom", int'(cmp_o), 5);
    // R5
    wr(0, 5); wr(1, 0); ticks(1, 1'b0, 1'b0);
    chk("R7 transfer after load to 0", int'(cmp_o), 3);
    wr(3, 3); ticks(4, 1'b1, 1'b0);
    chk("R5 clear at compare", int'(cnt_o), 0);
    chk("R5 ovf", int'(ovf_flag_o), 1);
    chk("R6 match in compare-top mode", int'(cmp_flag_o), 1);
    // R9 match block
    wr(3, 3); wr(1, 3); ticks(1, 1'b1, 1'b0);
    chk("R9 match blocked after load", int'(cmp_flag_o), 0);
    chk("R9 wrap still flagged", int'(ovf_flag_o), 1);
    // R8 collision: terminal strobe with clear in the same cycle
    wr(3, 3); ticks(3, 1'b1, 1'b0);
    chk("R8 pre-collision count", int'(cnt_o), 3);
    cyc(1'b1, 3, 3, 1'b1, 1'b0);
    chk("R8 set wins cmp", int'(cmp_flag_o), 1);
    chk("R8 set wins ovf", int'(ovf_flag_o), 1);
    wr(3, 3);
    chk("R8 clear alone", int'({cmp_flag_o, ovf_flag_o}), 0);
    // R9 load vs strobe
    wr(0, 1); cyc(1'b1, 1, 8'h40, 1'b1, 1'b0);
    chk("R9 load beats strobe", int'(cnt_o), 8'h40);
    ticks(1, 1'b1, 1'b0);
    chk("R9 count after load", int'(cnt_o), 8'h41);
    // R4
    wr(0, 9); wr(1, 2); wr(3, 3); ticks(3, 1'b1, 1'b0);
    chk("R4 down wrap to FF", int'(cnt_o), 8'hFF);
    chk("R4 down ovf", int'(ovf_flag_o), 1);
    wr(0, 13); wr(1, 1); wr(3, 3); ticks(2, 1'b1, 1'b0);
    chk("R4 down reload compare top", int'(cnt_o), 3);
    chk("R4 down ovf compare top", int'(ovf_flag_o), 1);
    // random mix checked by the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 8) cyc(1'b1, int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
                     1'(r & 1), 1'(($urandom_range(0, 1))));
      else if (r < 12) cyc(1'b1, 1, int'($urandom_range(0, 12)), 1'b1, 1'b1);
      else cyc(1'b0, 0, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    report();
    $finish;
  end
endmodule